// File: doc/BRIEF.md
# TDM Backplane Timing Monitor

This block supervises the two redundant timing pairs of a TDM backplane, called pair A and pair B. Each pair carries an 8.192 MHz bit clock and an active-low frame pulse. The monitored lines cross into a faster sampling clock through synchronizers. There the block measures the spacing of every bit-clock rising edge against a tolerance window and checks that each frame pulse is low for exactly one bit-clock cycle per frame period.

Every fault is recorded in a 16-bit sticky status register. Software clears a bit by writing a 1 to it. A timing fault sets two bits. The primary bit knocks the bus slave out of frame lock, and the slave then stops driving the bus data pins. The report-only copy has no influence on lock. The register also collects two alarm match pulses and two external "event lost" pulses. The status bit that marks lost framing is set out of reset, so software has to clear it before the slave may drive the bus.

Top module: `tdm_bus_monitor`

## Requirements
- R1: After reset the status register reads 16'h0100 (only bit 8, framing lost, set) and `bus_oe_o` is low.
- R2: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R3: Status bits 11:9 always read as 0, and writing to them has no effect.
- R4: `bus_oe_o` is high exactly when status bit 8 is clear. It follows bit 8 with no added delay.
- R5: A bit-clock rising edge whose spacing from the previous edge, counted in sampling ticks, lies outside NOM-TOL..NOM+TOL is a clock fault. So is the absence of any edge for more than NOM+TOL ticks. A fault on pair A sets bits 4 and 14. A fault on pair B sets bits 5 and 15.
- R6: A frame fault occurs when a frame pulse is low on two consecutive bit-clock rising edges, when the next low comes after some count of bit cycles other than FRAME_LEN, or when no low appears for FRAME_LEN bit cycles. A fault on pair A sets bits 2 and 12. A fault on pair B sets bits 3 and 13.
- R7: Any clock or frame fault sets bit 8. Bit 8 also stays set, and cannot be cleared, while any of bits 5:2 is set and not being cleared in the same write.
- R8: The copy bits 15:12 never set or hold bit 8. With only copy bits set, clearing bit 8 drives `bus_oe_o` high.
- R9: A pulse on `alarm_hit_i[0]` or `alarm_hit_i[1]` sets bit 0 or bit 1. A pulse on `evt_lost_i[0]` or `evt_lost_i[1]` sets bit 6 or bit 7. None of these pulses touches bit 8.
- R10: When a set condition and a write-one-to-clear hit the same bit in the same cycle, the bit ends up set.
- R11: A read (`reg_en_i`=1, `reg_we_i`=0) returns the register on `reg_rdata_o` one cycle later. `reg_rdata_o` then holds that value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bclk_a_i | input | 1 | Pair A bit clock (asynchronous) |
| fsync_a_ni | input | 1 | Pair A frame pulse, active low (asynchronous) |
| bclk_b_i | input | 1 | Pair B bit clock (asynchronous) |
| fsync_b_ni | input | 1 | Pair B frame pulse, active low (asynchronous) |
| alarm_hit_i | input | 2 | One-cycle alarm match pulses, index 0 and 1 |
| evt_lost_i | input | 2 | One-cycle event-lost pulses, index 0 = A, 1 = B |
| reg_en_i | input | 1 | Register access strobe |
| reg_we_i | input | 1 | 1 = write (one-to-clear), 0 = read |
| reg_wdata_i | input | 16 | Write data, 1 bits clear |
| reg_rdata_o | output | 16 | Read data, valid one cycle after a read |
| bus_oe_o | output | 1 | Bus data output enable, low = tri-state |

## Verification
The bench builds the block with a nominal bit-clock period of 8 sampling ticks, a tolerance of 2 ticks and a frame length of 16 bit cycles. A full frame is then only 128 clocks long, which puts early edges, late and missing edges, short frames, doubled low pulses and the lock-hold interplay between primary and copy bits within a few hundred cycles each. With the default 1024-cycle frame, a handful of frames would fill most of the run.

// File: rtl/tdm_mon_pkg.sv
package tdm_mon_pkg;
   localparam int unsigned STAT_W       = 16;
   localparam int unsigned NUM_PAIRS    = 2;
   // status bit positions (software decodes these)
   localparam int unsigned ST_ALARM0    = 0;
   localparam int unsigned ST_ALARM1    = 1;
   localparam int unsigned ST_FRM_BASE  = 2;
   localparam int unsigned ST_CLK_BASE  = 4;
   localparam int unsigned ST_LOST_BASE = 6;
   localparam int unsigned ST_UNLOCK    = 8;
   localparam int unsigned ST_COPY_BASE = 12;
   localparam logic [STAT_W-1:0] RSV_MASK  = 16'h0E00;
   localparam logic [STAT_W-1:0] STAT_INIT = 16'h0100;

   typedef logic [STAT_W-1:0] stat_t;
endpackage

// File: rtl/tdm_sync.sv
module tdm_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("tdm_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] pipe_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i) begin
         if (!rst_ni) pipe_q[s] <= RST_VAL;
         else if (s == 0) pipe_q[s] <= d_i;
         else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/tdm_bclk_check.sv
module tdm_bclk_check #(
   parameter int unsigned NOM_TICKS = 31,
   parameter int unsigned TOL_TICKS = 9
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic bclk_i,   // synchronized level
   output logic rise_o,   // one-tick pulse on each rising edge
   output logic bad_o     // one-tick fault pulse
);
   localparam int unsigned LO_TICKS = NOM_TICKS - TOL_TICKS;
   localparam int unsigned HI_TICKS = NOM_TICKS + TOL_TICKS;
   localparam int unsigned CW       = $clog2(HI_TICKS + 2);
   localparam logic [CW-1:0] CNT_MAX = CW'(HI_TICKS);

   if (TOL_TICKS >= NOM_TICKS) begin : g_bad_tol
      $error("tdm_bclk_check: TOL_TICKS must be below NOM_TICKS");
   end

   logic          prev_q, armed_q, bad_q;
   logic [CW-1:0] cnt_q;
   logic          rise, timeout, bad_d;
   int unsigned   span;

   assign rise    = bclk_i & ~prev_q;
   assign span    = int'(cnt_q) + 1;
   assign timeout = armed_q && !rise && (span == HI_TICKS + 1);

   always_comb begin
      bad_d = 1'b0;
      if (armed_q && rise) bad_d = (span < LO_TICKS) || (span > HI_TICKS);
      else if (timeout)    bad_d = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prev_q  <= 1'b0;
         armed_q <= 1'b0;
         cnt_q   <= '0;
         bad_q   <= 1'b0;
      end else begin
         prev_q <= bclk_i;
         bad_q  <= bad_d;
         if (rise) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
            if (timeout) armed_q <= 1'b0;
         end
      end
   end

   assign rise_o = rise;
   assign bad_o  = bad_q;

   // R5: a fault is a single-tick pulse
   assert_bad_single_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_o |=> !bad_o);
   // R5: a timeout disarms the checker until the next edge
   assert_timeout_disarms_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      timeout |=> !armed_q);
endmodule

// File: rtl/tdm_frame_check.sv
module tdm_frame_check #(
   parameter int unsigned FRAME_LEN = 1024
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic rise_i,     // bit-clock rising edge
   input  logic fsync_ni,   // synchronized frame level, active low
   output logic bad_o
);
   localparam int unsigned FW = $clog2(FRAME_LEN);
   localparam logic [FW-1:0] LAST = FW'(FRAME_LEN - 1);

   if (FRAME_LEN < 4) begin : g_bad_len
      $error("tdm_frame_check: FRAME_LEN must be at least 4");
   end

   logic [FW-1:0] cnt_q;
   logic          seen_q, prev_low_q, bad_q, bad_d;

   always_comb begin
      bad_d = 1'b0;
      if (rise_i) begin
         if (!fsync_ni) bad_d = prev_low_q || (seen_q && (cnt_q != LAST));
         else           bad_d = (cnt_q == LAST);
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q      <= '0;
         seen_q     <= 1'b0;
         prev_low_q <= 1'b0;
         bad_q      <= 1'b0;
      end else begin
         bad_q <= bad_d;
         if (rise_i) begin
            if (!fsync_ni) begin
               cnt_q      <= '0;
               seen_q     <= 1'b1;
               prev_low_q <= 1'b1;
            end else begin
               prev_low_q <= 1'b0;
               if (cnt_q == LAST) begin
                  cnt_q  <= '0;
                  seen_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + FW'(1);
               end
            end
         end
      end
   end

   assign bad_o = bad_q;

   // R6: verdicts are only produced on bit-clock edges
   assert_verdict_on_edge_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bad_d |-> rise_i);
   // R6: a low seen on two edges in a row always faults
   assert_long_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rise_i && !fsync_ni && prev_low_q) |=> bad_o);
endmodule

// File: rtl/tdm_status_reg.sv
module tdm_status_reg
   import tdm_mon_pkg::*;
(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic [1:0]  frm_bad_i,
   input  logic [1:0]  clk_bad_i,
   input  logic [1:0]  alarm_hit_i,
   input  logic [1:0]  evt_lost_i,
   input  logic        reg_en_i,
   input  logic        reg_we_i,
   input  stat_t       reg_wdata_i,
   output stat_t       reg_rdata_o,
   output logic        bus_oe_o
);
   stat_t stat_q, stat_d, set_vec, clr_vec, rdata_q;
   logic  fault_any, hold_lock;

   assign fault_any = |{frm_bad_i, clk_bad_i};
   assign clr_vec   = (reg_en_i && reg_we_i) ? reg_wdata_i : '0;

   always_comb begin
      set_vec = '0;
      set_vec[ST_ALARM0] = alarm_hit_i[0];
      set_vec[ST_ALARM1] = alarm_hit_i[1];
      for (int p = 0; p < int'(NUM_PAIRS); p++) begin
         set_vec[ST_FRM_BASE + p]  = frm_bad_i[p];
         set_vec[ST_CLK_BASE + p]  = clk_bad_i[p];
         set_vec[ST_LOST_BASE + p] = evt_lost_i[p];
         set_vec[ST_COPY_BASE + p]     = frm_bad_i[p];
         set_vec[ST_COPY_BASE + 2 + p] = clk_bad_i[p];
      end
      set_vec[ST_UNLOCK] = fault_any;
   end

   // primary fault bits that survive this cycle keep the slave unlocked
   assign hold_lock = |(stat_q[ST_CLK_BASE+1:ST_FRM_BASE] & ~clr_vec[ST_CLK_BASE+1:ST_FRM_BASE]);

   always_comb begin
      stat_d = ((stat_q & ~clr_vec) | set_vec) & ~RSV_MASK;
      if (hold_lock) stat_d[ST_UNLOCK] = 1'b1;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         stat_q  <= STAT_INIT;
         rdata_q <= '0;
      end else begin
         stat_q <= stat_d;
         if (reg_en_i && !reg_we_i) rdata_q <= stat_q;
      end
   end

   assign reg_rdata_o = rdata_q;
   assign bus_oe_o    = ~stat_q[ST_UNLOCK];

   // R10: a set request always lands, even against a clear
   for (genvar b = 0; b < int'(STAT_W); b++) begin : g_set_chk
      if (RSV_MASK[b] == 1'b0) begin : g_live
         assert_set_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
            set_vec[b] |=> stat_q[b]);
      end
   end
   // R7 / R4: any timing fault drops the output enable on the next cycle
   assert_fault_tristates_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      fault_any |=> !bus_oe_o);
   // R3: reserved field never reads back as nonzero
   assert_rsvd_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_rdata_o & RSV_MASK) == '0);
   // R2: a write of zero with nothing to set leaves the register as it was
   assert_write_zero_keeps_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_en_i && reg_we_i && reg_wdata_i == '0 && set_vec == '0) |=> $stable(stat_q));
   // R11: read data moves only after a read strobe
   assert_rdata_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(reg_en_i && !reg_we_i) |=> $stable(reg_rdata_o));
endmodule

// File: rtl/tdm_bus_monitor.sv
module tdm_bus_monitor
   import tdm_mon_pkg::*;
#(
   parameter int unsigned CLK_NOM_TICKS = 31,   // bit period at ~250 MHz sampling
   parameter int unsigned CLK_TOL_TICKS = 9,    // ~35 ns at ~250 MHz
   parameter int unsigned FRAME_LEN     = 1024,
   parameter int unsigned SYNC_STAGES   = 2
) (
   input  logic        clk_i,
   input  logic        rst_ni,
   input  logic        bclk_a_i,
   input  logic        fsync_a_ni,
   input  logic        bclk_b_i,
   input  logic        fsync_b_ni,
   input  logic [1:0]  alarm_hit_i,
   input  logic [1:0]  evt_lost_i,
   input  logic        reg_en_i,
   input  logic        reg_we_i,
   input  logic [15:0] reg_wdata_i,
   output logic [15:0] reg_rdata_o,
   output logic        bus_oe_o
);
   if (NUM_PAIRS != 2) begin : g_bad_pairs
      $error("tdm_bus_monitor: status layout assumes two pairs");
   end

   logic [NUM_PAIRS-1:0] bclk_raw, fs_raw, bclk_s, fs_s;
   logic [NUM_PAIRS-1:0] rise, clk_bad, frm_bad;

   assign bclk_raw = {bclk_b_i, bclk_a_i};
   assign fs_raw   = {fsync_b_ni, fsync_a_ni};

   tdm_sync #(.WIDTH(NUM_PAIRS), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_clk (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(bclk_raw), .q_o(bclk_s));

   tdm_sync #(.WIDTH(NUM_PAIRS), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_fs (
      .clk_i(clk_i), .rst_ni(rst_ni), .d_i(fs_raw), .q_o(fs_s));

   for (genvar p = 0; p < int'(NUM_PAIRS); p++) begin : g_pair
      tdm_bclk_check #(.NOM_TICKS(CLK_NOM_TICKS), .TOL_TICKS(CLK_TOL_TICKS)) u_clk (
         .clk_i(clk_i), .rst_ni(rst_ni), .bclk_i(bclk_s[p]),
         .rise_o(rise[p]), .bad_o(clk_bad[p]));

      tdm_frame_check #(.FRAME_LEN(FRAME_LEN)) u_frm (
         .clk_i(clk_i), .rst_ni(rst_ni), .rise_i(rise[p]),
         .fsync_ni(fs_s[p]), .bad_o(frm_bad[p]));
   end

   tdm_status_reg u_stat (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .frm_bad_i(frm_bad), .clk_bad_i(clk_bad),
      .alarm_hit_i(alarm_hit_i), .evt_lost_i(evt_lost_i),
      .reg_en_i(reg_en_i), .reg_we_i(reg_we_i), .reg_wdata_i(reg_wdata_i),
      .reg_rdata_o(reg_rdata_o), .bus_oe_o(bus_oe_o));

   // R1: the first cycle out of reset leaves the bus tri-stated
   assert_reset_tristate_R1: assert property (@(posedge clk_i)
      !rst_ni |=> !bus_oe_o);
endmodule

// File: tb/tdm_bus_monitor_tb.sv
module tdm_bus_monitor_tb_top;
   localparam int NOM = 8;
   localparam int TOL = 2;
   localparam int FLEN = 16;
   localparam int FRAME_TICKS = NOM * FLEN;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk_a = 1'b0, bclk_b = 1'b0, fs_a = 1'b1, fs_b = 1'b1;
   logic [1:0] alarm = '0, lost = '0;
   logic en = 1'b0, we = 1'b0;
   logic [15:0] wd = '0;
   logic [15:0] rd;
   logic oe;

   int per_a = NOM, per_b = NOM;
   int gap_a = FLEN, gap_b = FLEN;
   int wid_a = 1, wid_b = 1;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   tdm_bus_monitor #(.CLK_NOM_TICKS(NOM), .CLK_TOL_TICKS(TOL), .FRAME_LEN(FLEN)) dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .bclk_a_i(bclk_a), .fsync_a_ni(fs_a), .bclk_b_i(bclk_b), .fsync_b_ni(fs_b),
      .alarm_hit_i(alarm), .evt_lost_i(lost),
      .reg_en_i(en), .reg_we_i(we), .reg_wdata_i(wd),
      .reg_rdata_o(rd), .bus_oe_o(oe));

   // pair A timing generator; frame changes while the bit clock is low
   initial begin : gen_a
      int idx;
      idx = 0;
      forever begin
         int p;
         p = per_a;
         bclk_a = 1'b0;
         idx = (idx >= gap_a - 1) ? 0 : idx + 1;
         fs_a = (idx < wid_a) ? 1'b0 : 1'b1;
         repeat (p - p/2) @(negedge clk);
         bclk_a = 1'b1;
         repeat (p/2) @(negedge clk);
      end
   end

   initial begin : gen_b
      int idx;
      idx = 5;
      forever begin
         int p;
         p = per_b;
         bclk_b = 1'b0;
         idx = (idx >= gap_b - 1) ? 0 : idx + 1;
         fs_b = (idx < wid_b) ? 1'b0 : 1'b1;
         repeat (p - p/2) @(negedge clk);
         bclk_b = 1'b1;
         repeat (p/2) @(negedge clk);
      end
   end

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic reg_read(output logic [15:0] v);
      @(negedge clk); en = 1'b1; we = 1'b0;
      @(negedge clk); en = 1'b0; v = rd;
   endtask

   task automatic reg_write(input logic [15:0] v);
      @(negedge clk); en = 1'b1; we = 1'b1; wd = v;
      @(negedge clk); en = 1'b0; we = 1'b0; wd = '0;
   endtask

   task automatic settle();
      repeat (3 * FRAME_TICKS) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [15:0] v;
      reg_read(v);
      check("R1 status after reset", v, 16'h0100);
      check("R1 oe after reset", {15'd0, oe}, 16'h0000);
   endtask

   task automatic t_clear_and_quiet();
      logic [15:0] v;
      reg_write(16'h0100);
      reg_read(v);
      check("R2 clear framing-lost", v, 16'h0000);
      check("R4 oe after clear", {15'd0, oe}, 16'h0001);
      settle();
      reg_read(v);
      check("R5 R6 clean timing raises nothing", v, 16'h0000);
   endtask

   task automatic t_clk_late_a();
      logic [15:0] v;
      per_a = 12;
      repeat (5 * 12) @(negedge clk);
      per_a = NOM;
      settle();
      reg_read(v);
      check("R5 late clock A", v, 16'h4110);
      check("R4 oe low after clock fault", {15'd0, oe}, 16'h0000);
   endtask

   task automatic t_lock_hold();
      logic [15:0] v;
      reg_write(16'h0100);
      reg_read(v);
      check("R7 unlock held by primary bit", v, 16'h4110);
      reg_write(16'h0010);
      reg_read(v);
      check("R2 R7 clear primary only", v, 16'h4100);
      reg_write(16'h0100);
      reg_read(v);
      check("R8 copy does not hold lock", v, 16'h4000);
      check("R8 oe high with copy set", {15'd0, oe}, 16'h0001);
      reg_write(16'h4000);
      reg_read(v);
      check("R2 copy cleared", v, 16'h0000);
   endtask

   task automatic t_clk_early_b();
      logic [15:0] v;
      per_b = 5;
      repeat (5 * 5) @(negedge clk);
      per_b = NOM;
      settle();
      reg_read(v);
      check("R5 early clock B", v, 16'h8120);
      reg_write(16'h8120);
      reg_read(v);
      check("R7 single write clears fault and lock", v, 16'h0000);
   endtask

   task automatic t_frame_short_a();
      logic [15:0] v;
      gap_a = 12;
      repeat (2 * 12 * NOM) @(negedge clk);
      gap_a = FLEN;
      settle();
      reg_read(v);
      check("R6 short frame A", v, 16'h1104);
      reg_write(16'hFFFF);
   endtask

   task automatic t_frame_wide_b();
      logic [15:0] v;
      wid_b = 2;
      repeat (2 * FRAME_TICKS) @(negedge clk);
      wid_b = 1;
      settle();
      reg_read(v);
      check("R6 double-low frame B", v, 16'h2108);
      reg_write(16'hFFFF);
      reg_read(v);
      check("R3 reserved read zero after clear-all", v, 16'h0000);
   endtask

   task automatic t_alarm_events();
      logic [15:0] v;
      // set-wins: pulse alarm 0 in the same cycle as its clear
      @(negedge clk); en = 1'b1; we = 1'b1; wd = 16'h0001; alarm = 2'b01;
      @(negedge clk); en = 1'b0; we = 1'b0; wd = '0; alarm = 2'b00;
      reg_read(v);
      check("R10 set beats clear", v, 16'h0001);
      @(negedge clk); lost = 2'b10;
      @(negedge clk); lost = 2'b00;
      reg_read(v);
      check("R9 event lost B", v, 16'h0081);
      check("R9 oe unaffected by events", {15'd0, oe}, 16'h0001);
      reg_write(16'h0000);
      reg_read(v);
      check("R2 write zero keeps bits", v, 16'h0081);
      reg_write(16'h0E00);
      reg_read(v);
      check("R3 reserved write ignored", v, 16'h0081);
      @(negedge clk); alarm = 2'b10;
      @(negedge clk); alarm = 2'b00;
      @(negedge clk);
      check("R11 rdata holds without read", rd, 16'h0081);
      reg_read(v);
      check("R9 alarm 1 seen on next read", v, 16'h0083);
      reg_write(16'hFFFF);
      reg_read(v);
      check("R2 clear all", v, 16'h0000);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin : main
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clear_and_quiet();
      t_clk_late_a();
      t_lock_hold();
      t_clk_early_b();
      t_frame_short_a();
      t_frame_wide_b();
      t_alarm_events();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule